// File: doc/BRIEF.md
# CRC-32 Memory Consistency Checker

This block is a bus slave that folds every value written to its data port into a running CRC-32 remainder built on the generator 0x04C11DB7. A bus master, typically a DMA channel copying a memory region word by word, writes each value it reads into the data port. When the region is done, the master or a processor reads back the remainder and compares it with a value stored earlier. Any master may drive the bus. The block does not care who issues the writes.

Each data write carries a size code, and the remainder advances by exactly 8, 16 or 32 data bits to match it. Writing the checksum register loads a new starting value, so one engine can check several regions one after another. The checksum register always holds the raw remainder, with no final inversion.

A two-state control machine handles the bus. In `ST_IDLE` the block is ready. It performs writes in place and stays in `ST_IDLE`. An accepted read moves it to `ST_READ_RSP` (transition `RD_ACCEPT`), where the response is presented for one cycle with ready low. It then returns to `ST_IDLE` (transition `RSP_DONE`).

Top module: `crc_chk_top`

## Requirements
- R1: After reset the checksum register holds 0xFFFFFFFF, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write to byte offset 0x0 (`req_addr[3:2]` = 0) with `req_size` = 2'b00 advances the remainder by `req_wdata[7:0]` only. Bits enter least significant first, using the bit-reversed generator 0xEDB88320 on a right-shifting register. `req_wdata[31:8]` has no effect.
- R3: With `req_size` = 2'b01, the data write consumes `req_wdata[7:0]` first and then `req_wdata[15:8]`. `req_wdata[31:16]` has no effect.
- R4: With `req_size` = 2'b10, the data write consumes bytes 0, 1, 2 and 3 of `req_wdata`, in that order.
- R5: A data write with `req_size` = 2'b11 leaves the checksum unchanged.
- R6: Seeded with 0xFFFFFFFF, the ASCII bytes "123456789" give 0x340BC6D9, whatever mix of sizes delivers them.
- R7: A write to byte offset 0x4 (`req_addr[3:2]` = 1) loads all 32 bits of `req_wdata` into the checksum, whatever the size code.
- R8: A read of offset 0x4 returns the checksum. Reads of offsets 0x0, 0x8 and 0xC return 0. Writes to 0x8 and 0xC change nothing.
- R9: A read is accepted when `req_valid`, `req_ready` and not `req_write` are all true. `rsp_valid` is high for exactly the next cycle, with `req_ready` low in that cycle. `rsp_valid` is never high otherwise.
- R10: A data write is complete at the edge that accepts it. A read accepted on the very next edge returns the updated checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address; bits [3:2] select the register |
| req_size | input | 2 | Write size: 00 byte, 01 halfword, 10 word, 11 reserved |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The known nine-byte check string is delivered three ways: byte by byte, as halfwords with a trailing byte, and as words with a trailing byte. All three must reach the same remainder, which separates a correct per-lane bit order and byte order from a swapped one. Byte and halfword writes carry junk in their unused upper lanes, which exposes any leak of those lanes into the update. Seed loads, reserved size codes and unmapped offsets are each followed at once by a read of the checksum. Back-to-back write-then-read pairs confirm that the update is visible on the next edge.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

    localparam int CRC_W  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        REG_DATA   = 2'd0,
        REG_CSUM   = 2'd1,
        REG_SPARE0 = 2'd2,
        REG_SPARE1 = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_READ_RSP = 1'b1
    } bus_state_e;

    // Mirror a vector end for end; turns the normal-form generator
    // into the form used by a right-shifting register.
    function automatic logic [CRC_W-1:0] mirror(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) begin
            r[i] = v[CRC_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_chk_lane.sv
// One byte of CRC advance: eight serial steps, least significant bit first.
module crc_chk_lane #(
    parameter int CRC_W   = 32,
    parameter logic [CRC_W-1:0] POLY_R = 32'hEDB88320
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       byte_in,
    output logic [CRC_W-1:0] crc_out
);

    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (acc[0] ^ byte_in[b]) begin
                acc = (acc >> 1) ^ POLY_R;
            end else begin
                acc = acc >> 1;
            end
        end
        crc_out = acc;
    end

endmodule

// File: rtl/crc_chk_engine.sv
// Chains one lane per data byte and picks the tap that matches the size.
module crc_chk_engine
    import crc_chk_pkg::*;
#(
    parameter int CRC_W  = 32,
    parameter int DATA_W = 32,
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        size_in,
    output logic [CRC_W-1:0]  crc_out,
    output logic              size_ok
);

    localparam int LANES = DATA_W / 8;
    localparam logic [CRC_W-1:0] POLY_R = mirror(POLY);

    logic [CRC_W-1:0] tap [0:LANES];

    assign tap[0] = crc_in;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        crc_chk_lane #(
            .CRC_W  (CRC_W),
            .POLY_R (POLY_R)
        ) u_lane (
            .crc_in  (tap[g]),
            .byte_in (data_in[8*g +: 8]),
            .crc_out (tap[g+1])
        );
    end

    always_comb begin
        size_ok = 1'b1;
        crc_out = crc_in;
        unique case (xfer_size_e'(size_in))
            SZ_BYTE: crc_out = tap[1];
            SZ_HALF: crc_out = tap[(LANES >= 2) ? 2 : LANES];
            SZ_WORD: crc_out = tap[LANES];
            SZ_RSVD: begin
                crc_out = crc_in;
                size_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/crc_chk_decode.sv
// Address and command decode for accepted requests.
module crc_chk_decode
    import crc_chk_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              accept,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    output logic              data_wr,
    output logic              csum_wr,
    output logic              rd_acc,
    output logic              rd_csum
);

    reg_sel_e sel;

    always_comb begin
        sel     = reg_sel_e'(addr[3:2]);
        data_wr = 1'b0;
        csum_wr = 1'b0;
        rd_acc  = accept && !is_write;
        rd_csum = 1'b0;
        unique case (sel)
            REG_DATA: data_wr = accept && is_write;
            REG_CSUM: begin
                csum_wr = accept && is_write;
                rd_csum = accept && !is_write;
            end
            REG_SPARE0, REG_SPARE1: ;
        endcase
    end

endmodule

// File: rtl/crc_chk_top.sv
module crc_chk_top
    import crc_chk_pkg::*;
#(
    parameter int CRC_W  = crc_chk_pkg::CRC_W,
    parameter int DATA_W = crc_chk_pkg::DATA_W,
    parameter int ADDR_W = crc_chk_pkg::ADDR_W,
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
    parameter logic [CRC_W-1:0] SEED = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    bus_state_e       state_q, state_d;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic             size_ok;
    logic             accept;
    logic             data_wr, csum_wr, rd_acc, rd_csum;
    logic [DATA_W-1:0] rdata_q;

    assign accept = req_valid && req_ready;

    crc_chk_decode #(.ADDR_W(ADDR_W)) u_decode (
        .accept   (accept),
        .is_write (req_write),
        .addr     (req_addr),
        .data_wr  (data_wr),
        .csum_wr  (csum_wr),
        .rd_acc   (rd_acc),
        .rd_csum  (rd_csum)
    );

    crc_chk_engine #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_engine (
        .crc_in  (crc_q),
        .data_in (req_wdata),
        .size_in (req_size),
        .crc_out (crc_next),
        .size_ok (size_ok)
    );

    // Next-state logic: RD_ACCEPT and RSP_DONE transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (rd_acc) state_d = ST_READ_RSP;
            ST_READ_RSP: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Checksum and read-data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q   <= SEED;
            rdata_q <= '0;
        end else begin
            if (csum_wr) begin
                crc_q <= req_wdata[CRC_W-1:0];
            end else if (data_wr && size_ok) begin
                crc_q <= crc_next;
            end
            if (rd_acc) begin
                rdata_q <= rd_csum ? DATA_W'(crc_q) : '0;
            end
        end
    end

    // Outputs by state.
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_READ_RSP: rsp_valid = 1'b1;
        endcase
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/crc_chk_sva.sv
module crc_chk_sva #(
    parameter int CRC_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] req_wdata,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [CRC_W-1:0]  crc_q
);

    logic acc_rd, acc_wr;
    assign acc_rd = req_valid && req_ready && !req_write;
    assign acc_wr = req_valid && req_ready && req_write;

    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rsp_valid); // R9
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_rd)); // R9
    AST_BUSY_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R9
    AST_RSVD_SIZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && req_addr[3:2] == 2'd0 && req_size == 2'b11) |=> $stable(crc_q)); // R5
    AST_SPARE_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && req_addr[3]) |=> $stable(crc_q)); // R8
    AST_SEED_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && req_addr[3:2] == 2'd1) |=> crc_q == $past(req_wdata[CRC_W-1:0])); // R7
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> $stable(crc_q)); // R10
    AST_CSUM_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && req_addr[3:2] == 2'd1) |=> rsp_rdata == DATA_W'($past(crc_q))); // R8
    AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && req_addr[3:2] != 2'd1) |=> rsp_rdata == '0); // R8

endmodule

bind crc_chk_top crc_chk_sva #(
    .CRC_W  (CRC_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .crc_q     (crc_q)
);

// File: tb/crc_chk_top_tb_top.sv
module crc_chk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int compared = 0;
    int mismatched = 0;
    bit summary_done = 1'b0;

    logic [31:0] model = 32'hFFFFFFFF;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    crc_chk_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // Reference: bit-serial, LSB first, right-shifting with 0xEDB88320.
    function automatic logic [31:0] ref_adv(input logic [31:0] c, input logic [31:0] d, input int nbytes);
        for (int k = 0; k < nbytes * 8; k++) begin
            c = ((c[0] ^ d[k]) != 1'b0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c;
    endfunction

    function automatic void check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endfunction

    task automatic issue(input logic wr, input logic [3:0] addr, input logic [1:0] size, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = data;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic wr_reg(input logic [3:0] addr, input logic [1:0] size, input logic [31:0] data);
        issue(1'b1, addr, size, data);
        if (addr[3:2] == 2'd0 && size != 2'b11) begin
            model = ref_adv(model, data, (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4);
        end else if (addr[3:2] == 2'd1) begin
            model = data;
        end
    endtask

    task automatic rd_reg(input logic [3:0] addr, input string tag);
        exp_q.push_back((addr[3:2] == 2'd1) ? model : 32'h0);
        tag_q.push_back(tag);
        issue(1'b0, addr, 2'b10, 32'h0);
    endtask

    task automatic go_idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected rsp", rsp_rdata, 32'hxxxxxxxx);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rsp_rdata, e);
                check("R9 ready low during rsp", {31'b0, req_ready}, 32'h0);
            end
        end
    end

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 ready after reset", {31'b0, req_ready}, 32'h1);
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        rd_reg(4'h4, "R1 reset checksum");

        // R2 R6: byte by byte with junk in upper lanes
        for (int i = 0; i < 9; i++) wr_reg(4'h0, 2'b00, {24'hA5C3E1, 8'h31 + 8'(i)});
        rd_reg(4'h4, "R2 byte stream");
        go_idle();
        check("R6 check value bytes", model, 32'h340BC6D9);

        // R7 R3 R6: reseed, halfwords with junk above
        wr_reg(4'h4, 2'b00, 32'hFFFFFFFF);
        rd_reg(4'h4, "R7 seed load");
        wr_reg(4'h0, 2'b01, 32'hDEAD3231);
        wr_reg(4'h0, 2'b01, 32'hBEEF3433);
        wr_reg(4'h0, 2'b01, 32'h12343635);
        wr_reg(4'h0, 2'b01, 32'h56783837);
        wr_reg(4'h0, 2'b00, 32'hFFFFFF39);
        rd_reg(4'h4, "R3 halfword stream");
        check("R6 check value halfwords", model, 32'h340BC6D9);

        // R4 R6: words
        wr_reg(4'h4, 2'b10, 32'hFFFFFFFF);
        wr_reg(4'h0, 2'b10, 32'h34333231);
        wr_reg(4'h0, 2'b10, 32'h38373635);
        wr_reg(4'h0, 2'b00, 32'h00000039);
        rd_reg(4'h4, "R4 word stream");
        check("R6 check value words", model, 32'h340BC6D9);

        // R5: reserved size has no effect
        wr_reg(4'h0, 2'b11, 32'h0BADF00D);
        rd_reg(4'h4, "R5 reserved size");

        // R8: spare writes ignored, non-checksum reads return 0
        wr_reg(4'h8, 2'b10, 32'h11111111);
        wr_reg(4'hC, 2'b10, 32'h22222222);
        rd_reg(4'h4, "R8 spare writes ignored");
        rd_reg(4'h0, "R8 data offset reads 0");
        rd_reg(4'h8, "R8 spare offset reads 0");

        // R7 R10: odd seed, then write immediately followed by read
        wr_reg(4'h4, 2'b01, 32'h12345678);
        rd_reg(4'h4, "R7 full-width seed");
        wr_reg(4'h0, 2'b10, 32'hCAFEBABE);
        rd_reg(4'h4, "R10 read after word write");
        wr_reg(4'h0, 2'b00, 32'h00000000);
        rd_reg(4'h4, "R10 read after byte write");
        wr_reg(4'h0, 2'b01, 32'hFFFF8001);
        rd_reg(4'h4, "R10 read after half write");
        go_idle();

        repeat (4) @(negedge clk);
        check("R9 all responses seen", exp_q.size(), 32'h0);
        finish_run();
    end

endmodule